// File: doc/BRIEF.md
# PCM Codec Timeslot Control Port

This block is the serial front end of a telephone-style PCM filter/codec. All serial traffic runs on one bit clock (2.048 MHz in the target system). A frame lasts 125 µs, which is 256 bit periods, and an 8-bit word occupies an 8-clock slot inside that frame. An active-low strobe marks each slot. During a slot the block can do three things: shift one PCM word out, shift one PCM word in, and capture an 8-bit control word from a separate serial input. A two-bit address code, sampled with the first bit of the slot, decides where the control word goes. Register A holds the gain, loopback and powerdown settings. Register B holds six general-purpose outputs and two test-selection bits.

The address code selects one of three operating styles. In the first, the control input is tied to a constant level: low means normal operation and high means powerdown. In the second, a serial word is written to register A on every strobe and register B is forced to zero. In the third, there are two strobes per frame. The first strobe uses address code 0 or 1 and loads register A. The second uses code 2 and loads register B, and PCM transfer is suppressed for that slot.

On the parallel side, PCM words move over valid/ready streams. The transmit stream is offered one word at the start of each slot that carries PCM. A slot's received word is offered on the receive stream until the consumer accepts it. The consumer applies back-pressure by holding `rx_ready` low. If a new word completes while the previous one is still held, the new word is dropped and the held word is kept.

Top module: `pcm_tsc_port`

## Requirements
- R1: While `rst` is high at a rising edge, both control registers clear, `pcm_oe` and `pcm_out` go to 0, `rx_valid` goes to 0 and the bit counter returns to the start of a slot.
- R2: `pcm_oe` is high for exactly the 8 bit periods that start one rising edge after the first strobed bit is sampled, and only in slots that carry PCM. `pcm_out` presents the word MSB first and is 0 whenever `pcm_oe` is low.
- R3: A complete slot with address code 1 writes the control word into register A, leaves register B unchanged and delivers the sampled PCM word on the receive stream.
- R4: A complete slot with address code 0 whose control word is neither 0x00 nor 0xFF writes register A and clears register B to zero.
- R5: A complete slot with address code 0 whose control word is 0x00 or 0xFF (a constant control level) writes register A and leaves register B unchanged. The value 0xFF therefore sets the powerdown bit.
- R6: Bit 0 of register A is the powerdown bit. While it is set when a slot starts, that slot keeps `pcm_oe` low, never raises `tx_ready` and delivers no receive word. Control words are still captured.
- R7: A complete slot with address code 2 or 3 writes register B, leaves register A unchanged and moves no PCM data in either direction.
- R8: `gp_out` equals register B bits 5..0 and `test_sel` equals register B bits 7..6.
- R9: Once `rx_valid` is high it stays high with `rx_data` unchanged until a rising edge with `rx_ready` high. A word that completes while the previous word is still held is discarded. Acceptance and a new completion at the same edge hand over the new word.
- R10: `tx_ready` is high only between the first sample and the next rising edge of a slot that carries PCM. If `tx_valid` is high at that edge, `tx_data` is taken and transmitted. Otherwise the idle word 0xFF is sent.
- R11: A strobe that ends before 8 bits have been sampled changes no register and produces no receive word. The next strobe starts a fresh word.
- R12: Serial inputs are sampled on the falling clock edge, MSB first. A register takes its new value at the rising edge that follows the falling edge that sampled the eighth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_n | input | 1 | Active-low slot strobe |
| addr_code | input | 2 | Control word destination: 0 low, 1 middle, 2/3 high |
| ctl_in | input | 1 | Serial control input |
| pcm_in | input | 1 | Serial PCM receive input |
| pcm_out | output | 1 | Serial PCM transmit data |
| pcm_oe | output | 1 | Drive enable for the PCM output pad (low = high impedance) |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word taken at the next rising edge |
| tx_data | input | 8 | Transmit PCM word |
| rx_valid | output | 1 | Received word held |
| rx_ready | input | 1 | Consumer accepts the held word |
| rx_data | output | 8 | Received PCM word |
| ctl_a | output | 8 | Register A contents (bit 0 = powerdown) |
| gp_out | output | 6 | General-purpose outputs from register B |
| test_sel | output | 2 | Test-selection bits from register B |

## Verification
Two things can land on the same rising edge. One is the commit of a newly received PCM word. The other is the consumer's acceptance of the word already held. The bench provokes this by holding `rx_ready` low through one slot and raising it only with the eighth bit of the next slot. It then requires both words to reach the consumer in order, with no gap and no loss. A second coincidence comes from two back-to-back strobes in the two-slot style: the register A commit and the start of the register B slot share one edge. Every clock, the bench checks that the second slot is suppressed for PCM while register A already holds its new value.

// File: rtl/pcm_tsc_pkg.sv
package pcm_tsc_pkg;
  typedef enum logic [1:0] {
    ADDR_LOW  = 2'd0,
    ADDR_MID  = 2'd1,
    ADDR_HIGH = 2'd2,
    ADDR_RSVD = 2'd3
  } addr_code_e;

  // Codes 2 and 3 both steer the word to register B.
  function automatic logic addr_is_high(input logic [1:0] code);
    return code[1];
  endfunction
endpackage

// File: rtl/pcm_tsc_sampler.sv
// Falling-edge capture of the serial pins.
module pcm_tsc_sampler #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(negedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/pcm_tsc_slot.sv
// Bit counter, deserialisers and per-slot attributes.
module pcm_tsc_slot
  import pcm_tsc_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_s,
  input  logic [1:0]        addr_s,
  input  logic              ctl_s,
  input  logic              pcm_s,
  input  logic              pd,
  output logic              slot_start,
  output logic              commit,
  output logic              pcm_ok_start,
  output logic              pcm_ok_q,
  output logic [1:0]        slot_addr_q,
  output logic [WORD_W-1:0] ctl_word,
  output logic [WORD_W-1:0] pcm_word
);
  localparam int IDX_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

  logic [IDX_W-1:0]  idx;
  logic [WORD_W-2:0] ctl_sr;
  logic [WORD_W-2:0] pcm_sr;

  assign slot_start   = en_s && (idx == '0);
  assign commit       = en_s && (idx == LAST_IDX);
  assign pcm_ok_start = !addr_is_high(addr_s) && !pd;
  assign ctl_word     = {ctl_sr, ctl_s};
  assign pcm_word     = {pcm_sr, pcm_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      idx         <= '0;
      ctl_sr      <= '0;
      pcm_sr      <= '0;
      pcm_ok_q    <= 1'b0;
      slot_addr_q <= '0;
    end else if (!en_s) begin
      idx <= '0;
    end else begin
      ctl_sr <= ctl_word[WORD_W-2:0];
      pcm_sr <= pcm_word[WORD_W-2:0];
      idx    <= commit ? '0 : idx + 1'b1;
      if (slot_start) begin
        slot_addr_q <= addr_s;
        pcm_ok_q    <= pcm_ok_start;
      end
    end
  end
endmodule

// File: rtl/pcm_tsc_ctlregs.sv
// Control registers A and B with the address-code steering rules.
module pcm_tsc_ctlregs
  import pcm_tsc_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [1:0]        slot_addr,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] reg_a,
  output logic [WORD_W-1:0] reg_b
);
  localparam logic [WORD_W-1:0] ALL_ONES = '1;

  logic static_lvl;
  assign static_lvl = (word == '0) || (word == ALL_ONES);

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_a <= '0;
      reg_b <= '0;
    end else if (commit) begin
      unique case (addr_code_e'(slot_addr))
        ADDR_LOW: begin
          reg_a <= word;
          if (!static_lvl) reg_b <= '0;
        end
        ADDR_MID:             reg_a <= word;
        ADDR_HIGH, ADDR_RSVD: reg_b <= word;
      endcase
    end
  end
endmodule

// File: rtl/pcm_tsc_tx.sv
// Transmit serialiser with pad enable and stream handshake.
module pcm_tsc_tx #(
  parameter int                WORD_W    = 8,
  parameter logic [WORD_W-1:0] IDLE_WORD = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_s,
  input  logic              slot_start,
  input  logic              pcm_ok_start,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              pcm_out,
  output logic              pcm_oe
);
  logic [WORD_W-1:0] sh;
  logic [WORD_W-1:0] first;

  assign first    = tx_valid ? tx_data : IDLE_WORD;
  assign tx_ready = slot_start && pcm_ok_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      pcm_oe  <= 1'b0;
      pcm_out <= 1'b0;
    end else if (!en_s) begin
      pcm_oe  <= 1'b0;
      pcm_out <= 1'b0;
    end else if (slot_start) begin
      pcm_oe  <= pcm_ok_start;
      pcm_out <= pcm_ok_start & first[WORD_W-1];
      sh      <= {first[WORD_W-2:0], 1'b0};
    end else begin
      pcm_out <= pcm_oe & sh[WORD_W-1];
      sh      <= {sh[WORD_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/pcm_tsc_rx.sv
// Receive holding stage with drop-when-full policy.
module pcm_tsc_rx #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic              pcm_ok_q,
  input  logic [WORD_W-1:0] pcm_word,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data
);
  logic load;
  assign load = commit && pcm_ok_q && (!rx_valid || rx_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (load) begin
      rx_valid <= 1'b1;
      rx_data  <= pcm_word;
    end else if (rx_ready) begin
      rx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pcm_tsc_port.sv
module pcm_tsc_port #(
  parameter int                WORD_W    = 8,
  parameter int                GP_W      = 6,
  parameter logic [WORD_W-1:0] IDLE_WORD = '1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   enable_n,
  input  logic [1:0]             addr_code,
  input  logic                   ctl_in,
  input  logic                   pcm_in,
  output logic                   pcm_out,
  output logic                   pcm_oe,
  input  logic                   tx_valid,
  output logic                   tx_ready,
  input  logic [WORD_W-1:0]      tx_data,
  output logic                   rx_valid,
  input  logic                   rx_ready,
  output logic [WORD_W-1:0]      rx_data,
  output logic [WORD_W-1:0]      ctl_a,
  output logic [GP_W-1:0]        gp_out,
  output logic [WORD_W-GP_W-1:0] test_sel
);
  localparam int SAMP_W = 5;

  logic [SAMP_W-1:0] samp_q;
  logic              en_s, ctl_s, pcm_s;
  logic [1:0]        addr_s;
  logic              slot_start, commit, pcm_ok_start, pcm_ok_q;
  logic [1:0]        slot_addr_q;
  logic [WORD_W-1:0] ctl_word, pcm_word, reg_a, reg_b;

  pcm_tsc_sampler #(.W(SAMP_W)) u_samp (
    .clk (clk),
    .rst (rst),
    .d   ({~enable_n, addr_code, ctl_in, pcm_in}),
    .q   (samp_q)
  );
  assign {en_s, addr_s, ctl_s, pcm_s} = samp_q;

  pcm_tsc_slot #(.WORD_W(WORD_W)) u_slot (
    .clk          (clk),
    .rst          (rst),
    .en_s         (en_s),
    .addr_s       (addr_s),
    .ctl_s        (ctl_s),
    .pcm_s        (pcm_s),
    .pd           (reg_a[0]),
    .slot_start   (slot_start),
    .commit       (commit),
    .pcm_ok_start (pcm_ok_start),
    .pcm_ok_q     (pcm_ok_q),
    .slot_addr_q  (slot_addr_q),
    .ctl_word     (ctl_word),
    .pcm_word     (pcm_word)
  );

  pcm_tsc_ctlregs #(.WORD_W(WORD_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .commit    (commit),
    .slot_addr (slot_addr_q),
    .word      (ctl_word),
    .reg_a     (reg_a),
    .reg_b     (reg_b)
  );

  pcm_tsc_tx #(.WORD_W(WORD_W), .IDLE_WORD(IDLE_WORD)) u_tx (
    .clk          (clk),
    .rst          (rst),
    .en_s         (en_s),
    .slot_start   (slot_start),
    .pcm_ok_start (pcm_ok_start),
    .tx_valid     (tx_valid),
    .tx_data      (tx_data),
    .tx_ready     (tx_ready),
    .pcm_out      (pcm_out),
    .pcm_oe       (pcm_oe)
  );

  pcm_tsc_rx #(.WORD_W(WORD_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .commit   (commit),
    .pcm_ok_q (pcm_ok_q),
    .pcm_word (pcm_word),
    .rx_ready (rx_ready),
    .rx_valid (rx_valid),
    .rx_data  (rx_data)
  );

  assign ctl_a    = reg_a;
  assign gp_out   = reg_b[GP_W-1:0];
  assign test_sel = reg_b[WORD_W-1:GP_W];
endmodule

// File: rtl/pcm_tsc_port_chk.sv
module pcm_tsc_port_chk #(
  parameter int WORD_W = 8,
  parameter int GP_W   = 6
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   en_s,
  input logic                   commit,
  input logic [1:0]             slot_addr,
  input logic                   pcm_oe,
  input logic                   tx_ready,
  input logic                   rx_valid,
  input logic                   rx_ready,
  input logic [WORD_W-1:0]      rx_data,
  input logic [WORD_W-1:0]      ctl_a,
  input logic [GP_W-1:0]        gp_out,
  input logic [WORD_W-GP_W-1:0] test_sel
);
  a_r2_oe_after_strobe: assert property (@(posedge clk) disable iff (rst)
    pcm_oe |-> $past(en_s));

  a_r10_ready_in_strobe: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> en_s);

  a_r6_pd_blocks_oe: assert property (@(posedge clk) disable iff (rst)
    $rose(pcm_oe) |-> !$past(ctl_a[0]));

  a_r9_rx_hold: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  a_r7_high_keeps_a: assert property (@(posedge clk) disable iff (rst)
    (commit && slot_addr[1]) |=> $stable(ctl_a));

  a_r3_mid_keeps_b: assert property (@(posedge clk) disable iff (rst)
    (commit && slot_addr == 2'd1) |=> ($stable(gp_out) && $stable(test_sel)));
endmodule

bind pcm_tsc_port pcm_tsc_port_chk #(.WORD_W(WORD_W), .GP_W(GP_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en_s      (en_s),
  .commit    (commit),
  .slot_addr (slot_addr_q),
  .pcm_oe    (pcm_oe),
  .tx_ready  (tx_ready),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .rx_data   (rx_data),
  .ctl_a     (ctl_a),
  .gp_out    (gp_out),
  .test_sel  (test_sel)
);

// File: tb/pcm_tsc_port_tb.sv
module pcm_tsc_port_tb_top;
  localparam int WD_CYCLES = 200000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst = 1'b1, enable_n = 1'b1, ctl_in = 1'b0, pcm_in = 1'b0;
  logic [1:0] addr_code = 2'd0;
  logic       tx_valid = 1'b0, rx_ready = 1'b0;
  logic [7:0] tx_data = 8'h00;
  wire        pcm_out, pcm_oe, tx_ready, rx_valid;
  wire  [7:0] rx_data, ctl_a;
  wire  [5:0] gp_out;
  wire  [1:0] test_sel;

  pcm_tsc_port dut_i (
    .clk(clk), .rst(rst), .enable_n(enable_n), .addr_code(addr_code),
    .ctl_in(ctl_in), .pcm_in(pcm_in), .pcm_out(pcm_out), .pcm_oe(pcm_oe),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .ctl_a(ctl_a), .gp_out(gp_out), .test_sel(test_sel)
  );

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic       m_en = 1'b0, m_ctl = 1'b0, m_pcm = 1'b0;
  logic [1:0] m_addr = 2'd0, s_addr = 2'd0;
  int         bi = 0;
  logic [7:0] ea = 8'h00, eb = 8'h00, cw = 8'h00, pw = 8'h00, txw = 8'h00, e_rd = 8'h00;
  logic       e_oe = 1'b0, e_out = 1'b0, e_rv = 1'b0, s_ok = 1'b0, take = 1'b0, pop_req = 1'b0;
  logic [7:0] txq[$], got[$], sent[$];
  logic [7:0] cap = 8'h00;
  int         capn = 0;

  always @(posedge clk) begin
    if (rst) begin
      ea = 0; eb = 0; e_oe = 0; e_out = 0; bi = 0; e_rv = 0; e_rd = 0;
    end else begin
      take = e_rv && rx_ready;
      if (m_en) begin
        if (bi == 0) begin
          s_addr = m_addr;
          s_ok   = (m_addr < 2) && !ea[0];
          txw    = 8'hFF;
          if (s_ok && tx_valid) begin txw = tx_data; pop_req = 1; end
          e_oe  = s_ok;
          e_out = s_ok ? txw[7] : 1'b0;
        end else begin
          e_out = e_oe ? txw[7-bi] : 1'b0;
        end
        cw = {cw[6:0], m_ctl};
        pw = {pw[6:0], m_pcm};
        bi++;
        if (bi == 8) begin
          bi = 0;
          if (s_addr >= 2) eb = cw;
          else if (s_addr == 1) ea = cw;
          else begin
            ea = cw;
            if (cw != 8'h00 && cw != 8'hFF) eb = 0;
          end
          if (s_ok && (!e_rv || rx_ready)) begin e_rv = 1; e_rd = pw; take = 0; end
        end
      end else begin
        bi = 0; e_oe = 0; e_out = 0;
      end
      if (take) e_rv = 0;
    end
  end

  // transmit source driven from a queue
  always @(posedge clk) begin
    #3;
    if (pop_req) begin void'(txq.pop_front()); pop_req = 0; end
    tx_valid = (txq.size() > 0);
    tx_data  = tx_valid ? txq[0] : 8'h00;
  end

  // per-clock comparison, away from the rising edge
  always @(negedge clk) begin
    m_en = !rst && !enable_n; m_addr = addr_code; m_ctl = ctl_in; m_pcm = pcm_in;
    #2;
    if (!rst) begin
      chk(pcm_oe === e_oe, "R2 pcm_oe", pcm_oe, e_oe);
      chk(pcm_out === e_out, "R2 pcm_out", pcm_out, e_out);
      chk(ctl_a === ea, "R3 ctl_a", ctl_a, ea);
      chk(gp_out === eb[5:0], "R8 gp_out", gp_out, eb[5:0]);
      chk(test_sel === eb[7:6], "R8 test_sel", test_sel, eb[7:6]);
      chk(rx_valid === e_rv, "R9 rx_valid", rx_valid, e_rv);
      if (e_rv) chk(rx_data === e_rd, "R9 rx_data", rx_data, e_rd);
      chk(tx_ready === (m_en && bi == 0 && !m_addr[1] && !ea[0]), "R10 tx_ready", tx_ready,
          (m_en && bi == 0 && !m_addr[1] && !ea[0]));
      if (rx_valid && rx_ready) got.push_back(rx_data);
      if (pcm_oe) begin
        cap = {cap[6:0], pcm_out}; capn++;
        if (capn == 8) begin sent.push_back(cap); capn = 0; end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; enable_n = 1'b1; end
  endtask

  task automatic slot(input logic [1:0] a, input logic [7:0] c, input logic [7:0] p,
                      input int nbits = 8, input bit keep = 0, input bit rdy_last = 0,
                      input bit tchk = 0);
    logic [7:0] prev;
    prev = ctl_a;
    for (int k = 0; k < nbits; k++) begin
      @(posedge clk); #1;
      enable_n = 1'b0; addr_code = a; ctl_in = c[7-k]; pcm_in = p[7-k];
      if (rdy_last && k == 7) rx_ready = 1'b1;
      if (tchk && k == 7) begin
        @(negedge clk); #3;
        chk(ctl_a === prev, "R12 ctl_a before final edge", ctl_a, prev);
      end
    end
    if (!keep) begin
      @(posedge clk); #1; enable_n = 1'b1;
      if (tchk) chk(ctl_a === c, "R12 ctl_a after final edge", ctl_a, c);
    end
  endtask

  bit wd_hit = 0;
  initial begin
    #(WD_CYCLES * 8);
    wd_hit = 1;
    errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int n_sent, n_got;
  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #3;
    chk(ctl_a === 8'h00, "R1 ctl_a after reset", ctl_a, 0);
    chk(gp_out === 6'h00, "R1 gp_out after reset", gp_out, 0);
    chk(pcm_oe === 1'b0, "R1 pcm_oe after reset", pcm_oe, 0);
    chk(rx_valid === 1'b0, "R1 rx_valid after reset", rx_valid, 0);
    rx_ready = 1'b1;

    // two-slot style, back to back: A then B
    @(posedge clk); #1; txq.push_back(8'hA5);
    idle(2);
    slot(2'd1, 8'h3C, 8'h96, 8, 1);
    slot(2'd2, 8'hE7, 8'h11);
    idle(10);
    chk(ctl_a === 8'h3C, "R3 register A from middle code", ctl_a, 8'h3C);
    chk(gp_out === 6'h27, "R8 gp_out from register B", gp_out, 6'h27);
    chk(test_sel === 2'd3, "R8 test_sel from register B", test_sel, 3);
    chk(got.size() == 1 && got[0] == 8'h96, "R3/R7 only middle slot received", got.size(), 1);
    chk(sent.size() == 1 && sent[0] == 8'hA5, "R10 tx word sent MSB first", sent.size() ? sent[0] : 0, 8'hA5);

    // serial word with low code: A loads, B cleared
    slot(2'd0, 8'h5A, 8'h22);
    idle(6);
    chk(ctl_a === 8'h5A && gp_out === 6'h00 && test_sel === 2'd0, "R4 B cleared", gp_out, 0);
    chk(sent[$] == 8'hFF, "R10 idle word with no tx_valid", sent[$], 8'hFF);

    // constant levels with low code keep B
    slot(2'd2, 8'hC3, 8'h00);
    idle(3);
    slot(2'd0, 8'h00, 8'h33);
    idle(3);
    chk(gp_out === 6'h03 && ctl_a === 8'h00, "R5 static low keeps B", gp_out, 6'h03);
    slot(2'd0, 8'hFF, 8'h34);
    idle(3);
    chk(gp_out === 6'h03 && ctl_a === 8'hFF, "R5 static high keeps B, sets A", ctl_a, 8'hFF);

    // powerdown slot: no PCM either way, control still captured
    @(posedge clk); #1; txq.push_back(8'h77);
    n_sent = sent.size(); n_got = got.size();
    slot(2'd1, 8'h80, 8'h44);
    idle(4);
    chk(sent.size() == n_sent, "R6 no transmit in powerdown", sent.size(), n_sent);
    chk(got.size() == n_got, "R6 no receive in powerdown", got.size(), n_got);
    chk(txq.size() == 1, "R6 tx word not taken in powerdown", txq.size(), 1);
    chk(ctl_a === 8'h80, "R6 control captured in powerdown", ctl_a, 8'h80);
    slot(2'd1, 8'h10, 8'h55);
    idle(4);
    chk(sent[$] == 8'h77, "R10 held word sent after powerdown", sent[$], 8'h77);
    chk(got[$] == 8'h55, "R3 receive after powerdown", got[$], 8'h55);

    // short strobe is discarded
    slot(2'd2, 8'hFF, 8'h00, 5);
    idle(4);
    chk(gp_out === 6'h03 && test_sel === 2'd3, "R11 short strobe leaves B", gp_out, 6'h03);
    slot(2'd1, 8'h42, 8'h5B, 8, 0, 0, 1);
    idle(3);
    chk(ctl_a === 8'h42, "R11 fresh word after short strobe", ctl_a, 8'h42);

    // back-pressure: second word dropped
    rx_ready = 1'b0;
    n_got = got.size();
    slot(2'd1, 8'h42, 8'h61);
    idle(3);
    slot(2'd1, 8'h42, 8'h62);
    idle(3);
    chk(rx_valid === 1'b1 && rx_data === 8'h61, "R9 first word held", rx_data, 8'h61);
    rx_ready = 1'b1;
    idle(3);
    chk(got.size() == n_got + 1 && got[$] == 8'h61, "R9 dropped word not delivered", got[$], 8'h61);

    // acceptance and new completion on one edge
    rx_ready = 1'b0;
    slot(2'd1, 8'h42, 8'h71);
    idle(3);
    slot(2'd1, 8'h42, 8'h72, 8, 0, 1);
    idle(4);
    chk(got.size() == n_got + 3 && got[$-1] == 8'h71 && got[$] == 8'h72,
        "R9 same-edge handover", got[$], 8'h72);

    idle(4);
    if (!wd_hit) begin
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule